// File: doc/BRIEF.md
# Biphase-Mark Serial Deframer

This block takes one serial line that carries clock and data together in biphase-mark code. The line is sampled by a fast local clock at four samples per half bit cell. The block measures the time between line edges and classes each interval as a half cell or a full cell. From these it rebuilds the bit stream, and it marks every recovered bit with a one-cycle enable that acts as the regenerated bit clock. If the line stops toggling for too long, the block reports loss of lock and starts over.

On top of the bit stream, a frame tracker hunts for a run of fourteen ones. Once it finds one, it reads an 8-bit command code and a 16-bit payload length, both most significant bit first. It then shifts the payload out on a gated shift clock with a data pin, for front-end initialization. Each recognised command code raises a one-cycle strobe for an internal control action. Command and payload traffic share the one line because they never overlap.

The serial line cannot be stalled, so the payload output has no back-pressure. A consumer has to accept each bit on the cycle its shift pulse is high.

Top module: `bmc_deframer`

## Requirements
- R1: Each bit cell produces exactly one `bit_en` pulse, issued after the edge that opens the following cell. `bit_val` is 1 when the cell had a transition at its midpoint and 0 when it had none.
- R2: `lock_lost` gives a one-cycle pulse when the line shows no edge for 12 sample clocks, which is 1.5 cell periods. After that pulse the frame tracker is back in hunting, and the first new edge only re-arms the interval timer.
- R3: While hunting, the 14th consecutive decoded 1 completes the sync word, and the very next bit is the command MSB.
- R4: The command is 8 bits, MSB first. Codes 0xA0+k with k < 4 pulse `cmd_stb[k]` for one cycle. At most one strobe bit is ever high.
- R5: Any other command code pulses `frame_err`, raises no strobe and no shift pulse, and returns to hunting, so that a following well-formed frame is still accepted.
- R6: A 16-bit length, MSB first, follows the command. Exactly that many payload bits follow the length.
- R7: Each payload bit gives one `init_sclk` pulse, with the bit on `init_sdata` during that pulse, in line order. `init_sclk` never pulses outside a payload.
- R8: A run of 14 ones inside a payload pulses `frame_err` on the 14th one. That bit is not shifted out, and the block returns to hunting.
- R9: While `rst_n` is low at a clock edge, every output is cleared to 0 and the tracker goes to hunting.
- R10: A length of zero gives the command strobe, no shift pulses, and an immediate return to hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 4 samples per half cell |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Biphase-mark serial line (asynchronous) |
| bit_en | output | 1 | Recovered bit-clock enable, one pulse per cell |
| bit_val | output | 1 | Decoded bit, valid while bit_en is high |
| lock_lost | output | 1 | Pulse when no edge is seen for 1.5 cells |
| cmd_stb | output | 4 | One-cycle command strobes, one per defined code |
| init_sclk | output | 1 | Gated payload shift pulse |
| init_sdata | output | 1 | Payload bit, valid while init_sclk is high |
| frame_err | output | 1 | Pulse on an undefined code or a sync run inside a payload |

## Verification
The assertions check a set of invariants on every cycle:
- the edge-interval counter never runs past the loss-of-lock limit;
- no bit is decoded the cycle after lock is lost;
- the command strobes stay one-hot or idle;
- shift pulses come only from the payload state;
- every frame error and every loss of lock leaves the tracker hunting.

The directed scenarios cover what no single cycle can show. They check that the decoded sequences match the transmitted cells, and that the right strobe fires for a given code. They also check the exact count and order of the payload bits, the truncation point when a sync run appears inside a payload, and recovery onto a fresh frame after an error or after the line goes idle.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_CMD  = 2'd1,
    ST_LEN  = 2'd2,
    ST_DATA = 2'd3
  } frm_state_e;
endpackage

// File: rtl/bmc_rx_decoder.sv
module bmc_rx_decoder #(
  parameter int OSR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic bit_en,
  output logic bit_val,
  output logic lock_lost
);
  localparam int LOST_LIM  = 3 * OSR;
  localparam int SHORT_CNT = (3 * OSR) / 2 - 1;
  localparam int CW        = $clog2(LOST_LIM + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt;
  logic          armed;
  logic          half_seen;
  logic          edge_det;

  assign edge_det = sync_q[2] ^ sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q    <= '0;
      cnt       <= '0;
      armed     <= 1'b0;
      half_seen <= 1'b0;
      bit_en    <= 1'b0;
      bit_val   <= 1'b0;
      lock_lost <= 1'b0;
    end else begin
      sync_q    <= {sync_q[1:0], line_in};
      bit_en    <= 1'b0;
      lock_lost <= 1'b0;
      if (edge_det) begin
        cnt   <= '0;
        armed <= 1'b1;
        if (armed) begin
          if (cnt < CW'(SHORT_CNT)) begin
            // half-cell interval: second one of a pair closes a '1' cell
            if (half_seen) begin
              bit_en    <= 1'b1;
              bit_val   <= 1'b1;
              half_seen <= 1'b0;
            end else begin
              half_seen <= 1'b1;
            end
          end else begin
            // full-cell interval: a '0' cell, also realigns pairing
            bit_en    <= 1'b1;
            bit_val   <= 1'b0;
            half_seen <= 1'b0;
          end
        end
      end else if (cnt == CW'(LOST_LIM)) begin
        lock_lost <= armed;
        armed     <= 1'b0;
        half_seen <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LOST_LIM));

  // R2
  no_bit_after_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |=> !bit_en);
endmodule

// File: rtl/bmc_frame_fsm.sv
module bmc_frame_fsm
  import bmc_pkg::*;
#(
  parameter int SYNC_LEN = 14,
  parameter int CMD_W    = 8,
  parameter int LEN_W    = 16,
  parameter int NUM_CMD  = 4,
  parameter int CMD_BASE = 'hA0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               bit_val,
  input  logic               lock_lost,
  output logic [NUM_CMD-1:0] cmd_stb,
  output logic               init_sclk,
  output logic               init_sdata,
  output logic               frame_err
);
  localparam int OW = $clog2(SYNC_LEN + 1);
  localparam int FW = $clog2(LEN_W + 1);

  frm_state_e       state;
  logic [OW-1:0]    ones;
  logic [OW-1:0]    ones_nxt;
  logic [FW-1:0]    fcnt;
  logic [LEN_W-1:0] shreg;
  logic [LEN_W-1:0] remain;
  logic [CMD_W-1:0] code_w;
  logic [LEN_W-1:0] len_w;
  int               off_i;
  logic             code_ok;
  logic             sync_hit;

  always_comb begin
    if (!bit_val)                    ones_nxt = '0;
    else if (ones == OW'(SYNC_LEN))  ones_nxt = ones;
    else                             ones_nxt = ones + 1'b1;
    sync_hit = (ones_nxt == OW'(SYNC_LEN));
    code_w   = {shreg[CMD_W-2:0], bit_val};
    len_w    = {shreg[LEN_W-2:0], bit_val};
    off_i    = int'(code_w) - CMD_BASE;
    code_ok  = (off_i >= 0) && (off_i < NUM_CMD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      ones       <= '0;
      fcnt       <= '0;
      shreg      <= '0;
      remain     <= '0;
      cmd_stb    <= '0;
      init_sclk  <= 1'b0;
      init_sdata <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      cmd_stb   <= '0;
      init_sclk <= 1'b0;
      frame_err <= 1'b0;
      if (lock_lost) begin
        state <= ST_HUNT;
        ones  <= '0;
      end else if (bit_en) begin
        shreg <= {shreg[LEN_W-2:0], bit_val};
        case (state)
          ST_HUNT: begin
            ones <= ones_nxt;
            if (sync_hit) begin
              state <= ST_CMD;
              fcnt  <= '0;
              ones  <= '0;
            end
          end
          ST_CMD: begin
            fcnt <= fcnt + 1'b1;
            if (fcnt == FW'(CMD_W - 1)) begin
              fcnt <= '0;
              if (code_ok) begin
                for (int k = 0; k < NUM_CMD; k++)
                  if (off_i == k) cmd_stb[k] <= 1'b1;
                state <= ST_LEN;
              end else begin
                frame_err <= 1'b1;
                state     <= ST_HUNT;
              end
            end
          end
          ST_LEN: begin
            fcnt <= fcnt + 1'b1;
            if (fcnt == FW'(LEN_W - 1)) begin
              fcnt   <= '0;
              remain <= len_w;
              ones   <= '0;
              state  <= (len_w == '0) ? ST_HUNT : ST_DATA;
            end
          end
          default: begin
            ones <= ones_nxt;
            if (sync_hit) begin
              frame_err <= 1'b1;
              ones      <= '0;
              state     <= ST_HUNT;
            end else begin
              init_sclk  <= 1'b1;
              init_sdata <= bit_val;
              remain     <= remain - 1'b1;
              if (remain == LEN_W'(1)) state <= ST_HUNT;
            end
          end
        endcase
      end
    end
  end

  // R4
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_stb));

  // R7
  sclk_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_sclk |-> $past(state) == ST_DATA);

  // R5
  err_hunts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> state == ST_HUNT);

  // R2
  loss_hunts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |=> state == ST_HUNT);
endmodule

// File: rtl/bmc_deframer.sv
module bmc_deframer #(
  parameter int OSR      = 4,
  parameter int SYNC_LEN = 14,
  parameter int CMD_W    = 8,
  parameter int LEN_W    = 16,
  parameter int NUM_CMD  = 4,
  parameter int CMD_BASE = 'hA0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_in,
  output logic               bit_en,
  output logic               bit_val,
  output logic               lock_lost,
  output logic [NUM_CMD-1:0] cmd_stb,
  output logic               init_sclk,
  output logic               init_sdata,
  output logic               frame_err
);
  bmc_rx_decoder #(.OSR(OSR)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .bit_en    (bit_en),
    .bit_val   (bit_val),
    .lock_lost (lock_lost)
  );

  bmc_frame_fsm #(
    .SYNC_LEN (SYNC_LEN),
    .CMD_W    (CMD_W),
    .LEN_W    (LEN_W),
    .NUM_CMD  (NUM_CMD),
    .CMD_BASE (CMD_BASE)
  ) u_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .bit_val    (bit_val),
    .lock_lost  (lock_lost),
    .cmd_stb    (cmd_stb),
    .init_sclk  (init_sclk),
    .init_sdata (init_sdata),
    .frame_err  (frame_err)
  );
endmodule

// File: tb/tb_bmc_deframer.sv
`timescale 1ns/1ps
module tb_bmc_deframer;
  localparam int OSR = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_in = 1'b0;
  logic       bit_en, bit_val, lock_lost, init_sclk, init_sdata, frame_err;
  logic [3:0] cmd_stb;

  int n_chk = 0;
  int n_fail = 0;

  // monitor state
  logic [63:0] bits_rx;
  int          bits_n;
  logic [63:0] pay_rx;
  int          pay_n;
  int          stb_n [4];
  int          err_n, lost_n;

  always #4 clk = ~clk;

  bmc_deframer dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .bit_en(bit_en), .bit_val(bit_val), .lock_lost(lock_lost),
    .cmd_stb(cmd_stb), .init_sclk(init_sclk), .init_sdata(init_sdata),
    .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_en) begin bits_rx = {bits_rx[62:0], bit_val}; bits_n++; end
      if (init_sclk) begin pay_rx = {pay_rx[62:0], init_sdata}; pay_n++; end
      for (int k = 0; k < 4; k++) if (cmd_stb[k]) stb_n[k]++;
      if (frame_err) err_n++;
      if (lock_lost) lost_n++;
    end
  end

  task automatic clear_mon();
    @(posedge clk); #1;
    bits_rx = '0; bits_n = 0; pay_rx = '0; pay_n = 0;
    for (int k = 0; k < 4; k++) stb_n[k] = 0;
    err_n = 0; lost_n = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_samples(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    line_in = ~line_in;
    wait_samples(OSR);
    if (b) line_in = ~line_in;
    wait_samples(OSR);
  endtask

  task automatic send_frame(input logic [7:0] code, input logic [15:0] len,
                            input logic [63:0] pay, input int npay);
    for (int i = 0; i < 4; i++)  send_bit(1'b0);
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    for (int i = 7; i >= 0; i--) send_bit(code[i]);
    for (int i = 15; i >= 0; i--) send_bit(len[i]);
    for (int i = npay - 1; i >= 0; i--) send_bit(pay[i]);
    send_bit(1'b0);
    send_bit(1'b0);
    wait_samples(40);
  endtask

  function automatic logic [63:0] mask(input int n);
    return (64'd1 << n) - 64'd1;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk({bit_en, bit_val, lock_lost, cmd_stb, init_sclk, init_sdata, frame_err} == '0,
        "R9 outputs idle in reset",
        {bit_en, bit_val, lock_lost, cmd_stb, init_sclk, init_sdata, frame_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_samples(4);
  endtask

  task automatic t_decode();
    logic [7:0] pat = 8'b1011_0010;
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    clear_mon();
    for (int i = 7; i >= 0; i--) send_bit(pat[i]);
    send_bit(1'b0);
    send_bit(1'b0);
    wait_samples(30);
    // decoded: trailing preamble 0, pattern, first trailing 0
    chk(bits_n == 10, "R1 decoded bit count", bits_n, 10);
    chk(bits_rx[9:0] == {1'b0, pat, 1'b0}, "R1 decoded values", bits_rx[9:0], {1'b0, pat, 1'b0});
    chk(lost_n == 1, "R2 one lock_lost on idle line", lost_n, 1);
    chk(pay_n == 0 && err_n == 0, "R7 no shift pulse outside frame", pay_n, 0);
  endtask

  task automatic t_good_frame();
    clear_mon();
    send_frame(8'hA2, 16'd12, 64'hA5C, 12);
    chk(stb_n[2] == 1, "R4 strobe for code A2", stb_n[2], 1);
    chk(stb_n[0] + stb_n[1] + stb_n[3] == 0, "R4 other strobes quiet",
        stb_n[0] + stb_n[1] + stb_n[3], 0);
    chk(pay_n == 12, "R6 payload bit count", pay_n, 12);
    chk((pay_rx & mask(12)) == 64'hA5C, "R7 payload order R3 alignment", pay_rx & mask(12), 64'hA5C);
    chk(err_n == 0, "R3 no frame error", err_n, 0);
  endtask

  task automatic t_zero_len();
    clear_mon();
    send_frame(8'hA0, 16'd0, 64'h0, 0);
    chk(stb_n[0] == 1, "R10 strobe for code A0", stb_n[0], 1);
    chk(pay_n == 0, "R10 no shift pulses", pay_n, 0);
    clear_mon();
    send_frame(8'hA3, 16'd3, 64'h5, 3);
    chk(stb_n[3] == 1 && pay_n == 3, "R10 back to hunting", pay_n, 3);
  endtask

  task automatic t_bad_code();
    clear_mon();
    send_frame(8'h37, 16'd6, 64'h2A, 6);
    chk(err_n == 1, "R5 frame_err on bad code", err_n, 1);
    chk(stb_n[0] + stb_n[1] + stb_n[2] + stb_n[3] == 0, "R5 no strobe",
        stb_n[0] + stb_n[1] + stb_n[2] + stb_n[3], 0);
    chk(pay_n == 0, "R5 no shift pulse", pay_n, 0);
    clear_mon();
    send_frame(8'hA1, 16'd5, 64'h16, 5);
    chk(stb_n[1] == 1 && (pay_rx & mask(5)) == 64'h16, "R5 recovery frame", pay_rx & mask(5), 64'h16);
  endtask

  task automatic t_sync_in_payload();
    clear_mon();
    // 5 zeros then 20 ones; 40 declared
    send_frame(8'hA1, 16'd40, 64'hFFFFF, 25);
    chk(err_n == 1, "R8 frame_err on sync in payload", err_n, 1);
    chk(pay_n == 18, "R8 shift stops before 14th one", pay_n, 18);
    chk((pay_rx & mask(18)) == 64'h1FFF, "R8 shifted bits", pay_rx & mask(18), 64'h1FFF);
  endtask

  task automatic t_lock_loss();
    clear_mon();
    for (int i = 0; i < 4; i++)  send_bit(1'b0);
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    for (int i = 7; i >= 0; i--) send_bit(8'hA3 >> i);
    for (int i = 15; i >= 0; i--) send_bit(16'd30 >> i);
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    wait_samples(40);
    chk(lost_n == 1, "R2 lock_lost mid payload", lost_n, 1);
    clear_mon();
    send_frame(8'hA1, 16'd4, 64'h9, 4);
    chk(stb_n[1] == 1, "R2 hunting after loss", stb_n[1], 1);
    chk(pay_n == 4 && (pay_rx & mask(4)) == 64'h9, "R2 fresh payload", pay_rx & mask(4), 64'h9);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bits_rx = '0; bits_n = 0; pay_rx = '0; pay_n = 0;
    for (int k = 0; k < 4; k++) stb_n[k] = 0;
    err_n = 0; lost_n = 0;
    repeat (3) @(posedge clk);
    t_reset();
    t_decode();
    t_good_frame();
    t_zero_len();
    t_bad_code();
    t_sync_in_payload();
    t_lock_loss();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule